// File: doc/BRIEF.md
# 32-bit Integer ALU with Registered Result

This block is the integer execute unit of a 32-bit load/store processor. Each cycle it takes two operands, a separate shift distance and a 4-bit operation code. The result and a zero flag are registered and appear one clock after the inputs are sampled. The unit covers wrapping add and subtract, the four bitwise operations (AND, OR, XOR and NOR), signed and unsigned set-less-than, and three shifts.

Subtraction adds the inverted second operand with a carry-in of one. The same adder gives both less-than compares. Signed less-than uses the operand signs and the difference sign. Unsigned less-than uses the carry out. Bitwise NOT is obtained as NOR with a zero second operand. Branch logic tests equality by issuing a subtract and looking at the zero flag. Overflow traps, multiply, divide and the register file sit outside this unit.

Top module: `int_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `result` = 0 and `zero_flag` = 1.
- R2: Op code 0 (add) gives `opnd_a + opnd_b` modulo 2^32 on `result` one clock edge after the inputs are sampled. It never traps.
- R3: Op code 1 (subtract) gives `opnd_a - opnd_b` modulo 2^32, formed as `opnd_a + ~opnd_b + 1`.
- R4: Op codes 2, 3 and 4 give the bitwise AND, OR and XOR of the operands.
- R5: Op code 5 gives `~(opnd_a | opnd_b)`. With `opnd_b` = 0 this is the bitwise NOT of `opnd_a`.
- R6: Op code 6 (signed less-than) gives 1 when `opnd_a` < `opnd_b` as two's-complement values, otherwise 0. For example, 0xFFFFFFFF versus 1 gives 1.
- R7: Op code 7 (unsigned less-than) gives 1 when `opnd_a` < `opnd_b` as unsigned values, otherwise 0. For example, 0xFFFFFFFF versus 1 gives 0.
- R8: Op code 8 shifts `opnd_b` left by `shamt` and fills the vacated bits with 0.
- R9: Op code 9 shifts `opnd_b` right by `shamt` and fills the vacated bits with 0.
- R10: Op code 10 shifts `opnd_b` right by `shamt` and fills the vacated bits with copies of bit 31.
- R11: The shift distance comes only from `shamt`. Shifts ignore `opnd_a`, and non-shift operations ignore `shamt`.
- R12: `zero_flag` is 1 exactly when the registered `result` is all zeros. A subtract of equal operands therefore raises it, and a subtract of unequal operands clears it.
- R13: Op codes 11 to 15 give `result` = 0 and `zero_flag` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand, also the value that is shifted |
| shamt | input | SHAMT_W | Shift distance |
| result | output | DATA_W | Registered result |
| zero_flag | output | 1 | Registered flag, high when result is zero |

## Verification
The bench uses the operand pair 0xFFFFFFFF and 1 to split the two compares. A design that shared one compare would give the same answer for both. Negative values with the maximum shift distance expose an arithmetic shift that fills with zeros, and a logical shift that fills with the sign bit. Wrapping sums, and compares between the most-negative and most-positive values, catch adders that lose the carry or compare sign bits the wrong way. Equal-operand subtracts and unused op codes check that the zero flag follows the result and that stray codes do not leak a value.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_NOR  = 4'd5,
    OP_SLT  = 4'd6,
    OP_SLTU = 4'd7,
    OP_SLL  = 4'd8,
    OP_SRL  = 4'd9,
    OP_SRA  = 4'd10
  } alu_op_e;
endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         lt_s,
  output logic         lt_u
);
  logic [W:0] ext;

  // invert-and-add-one subtraction; carry out clear means a borrow occurred
  always_comb begin
    ext  = {1'b0, a} + {1'b0, b ^ {W{sub}}} + {{W{1'b0}}, sub};
    sum  = ext[W-1:0];
    lt_u = ~ext[W];
    lt_s = (a[W-1] != b[W-1]) ? a[W-1] : ext[W-1];
  end
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
  parameter int W  = 32,
  parameter int SW = 5
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          left,
  input  logic          arith,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [0:SW];
  logic [W-1:0] rev_in;
  logic [W-1:0] rev_out;
  logic         fill;

  // left shifts reuse the right shifter on bit-reversed data
  always_comb begin
    for (int k = 0; k < W; k++) rev_in[k] = din[W-1-k];
  end

  assign fill   = arith & ~left & din[W-1];
  assign stg[0] = left ? rev_in : din;

  generate
    for (genvar i = 0; i < SW; i++) begin : g_stage
      localparam int D = 1 << i;
      if (D < W) begin : g_part
        assign stg[i+1] = amt[i] ? {{D{fill}}, stg[i][W-1:D]} : stg[i];
      end else begin : g_full
        assign stg[i+1] = amt[i] ? {W{fill}} : stg[i];
      end
    end
  endgenerate

  always_comb begin
    for (int k = 0; k < W; k++) rev_out[k] = stg[SW][W-1-k];
  end

  assign dout = left ? rev_out : stg[SW];
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOR:  y = ~(a | b);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [3:0]         op_sel,
  input  logic [DATA_W-1:0]  opnd_a,
  input  logic [DATA_W-1:0]  opnd_b,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [DATA_W-1:0]  result,
  output logic               zero_flag
);
  logic [DATA_W-1:0] sum_w, logic_w, shift_w, res_nxt;
  logic              lt_s_w, lt_u_w, is_sub, sh_left, sh_arith;

  assign is_sub   = (op_sel != OP_ADD);
  assign sh_left  = (op_sel == OP_SLL);
  assign sh_arith = (op_sel == OP_SRA);

  int_alu_addsub #(.W(DATA_W)) addsub_i (
    .a(opnd_a), .b(opnd_b), .sub(is_sub),
    .sum(sum_w), .lt_s(lt_s_w), .lt_u(lt_u_w)
  );

  int_alu_logic #(.W(DATA_W)) logic_i (
    .op(op_sel), .a(opnd_a), .b(opnd_b), .y(logic_w)
  );

  int_alu_shift #(.W(DATA_W), .SW(SHAMT_W)) shift_i (
    .din(opnd_b), .amt(shamt), .left(sh_left), .arith(sh_arith), .dout(shift_w)
  );

  always_comb begin
    case (op_sel)
      OP_ADD, OP_SUB:                 res_nxt = sum_w;
      OP_AND, OP_OR, OP_XOR, OP_NOR:  res_nxt = logic_w;
      OP_SLT:  res_nxt = {{(DATA_W-1){1'b0}}, lt_s_w};
      OP_SLTU: res_nxt = {{(DATA_W-1){1'b0}}, lt_u_w};
      OP_SLL, OP_SRL, OP_SRA:         res_nxt = shift_w;
      default: res_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      zero_flag <= 1'b1;
    end else begin
      result    <= res_nxt;
      zero_flag <= (res_nxt == '0);
    end
  end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        op_sel,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [DATA_W-1:0] result,
  input logic              zero_flag
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (result == '0 && zero_flag));

  // R12
  zero_match_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (zero_flag == (result == '0)));

  // R6
  slt_binary_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) == 4'd6) |-> (result[DATA_W-1:1] == '0));

  // R7
  sltu_binary_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) == 4'd7) |-> (result[DATA_W-1:1] == '0));

  // R13
  unused_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) > 4'd10) |-> (result == '0 && zero_flag));

  // R3
  sub_equal_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) == 4'd1 && $past(opnd_a) == $past(opnd_b)) |-> zero_flag);

  // R4
  and_value_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) == 4'd2) |-> (result == ($past(opnd_a) & $past(opnd_b))));
endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_a(opnd_a),
  .opnd_b(opnd_b), .result(result), .zero_flag(zero_flag)
);

// File: tb/int_alu_tb_top.sv
`timescale 1ns/1ps
module int_alu_tb_top;
  localparam int W  = 32;
  localparam int SW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    op_sel = '0;
  logic [W-1:0]  opnd_a = '0, opnd_b = '0;
  logic [SW-1:0] shamt = '0;
  logic [W-1:0]  result;
  logic          zero_flag;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  int_alu #(.DATA_W(W)) dut_i (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .shamt(shamt), .result(result), .zero_flag(zero_flag)
  );

  function automatic logic [W-1:0] model(input logic [3:0] op, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic [SW-1:0] s);
    case (op)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return a & b;
      4'd3:  return a | b;
      4'd4:  return a ^ b;
      4'd5:  return ~(a | b);
      4'd6:  return ($signed(a) < $signed(b)) ? 1 : 0;
      4'd7:  return (a < b) ? 1 : 0;
      4'd8:  return b << s;
      4'd9:  return b >> s;
      4'd10: return $unsigned($signed(b) >>> s);
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] exp_r);
    n_run++;
    if (result !== exp_r || zero_flag !== (exp_r == '0)) begin
      n_fail++;
      $display("FAIL %s: result=%h zero=%b expected result=%h zero=%b",
               req, result, zero_flag, exp_r, (exp_r == '0));
    end
  endtask

  // drive at falling edge, result registered at next rising edge, sample at following fall
  task automatic run(input string req, input logic [3:0] op, input logic [W-1:0] a,
                     input logic [W-1:0] b, input logic [SW-1:0] s);
    op_sel = op; opnd_a = a; opnd_b = b; shamt = s;
    @(negedge clk);
    check(req, model(op, a, b, s));
  endtask

  initial begin
    int lim = 0;
    while (!done && lim < 200000) begin
      @(posedge clk);
      lim++;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected completion", lim);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240914));
    rst = 1'b1; op_sel = 4'd0; opnd_a = 32'h1234_5678; opnd_b = 32'h1;
    repeat (3) @(negedge clk);
    check("R1", '0);
    rst = 1'b0;

    run("R2", 4'd0, 32'h0000_0005, 32'h0000_0007, 5'd0);
    run("R2", 4'd0, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0);
    run("R3", 4'd1, 32'h0000_0003, 32'h0000_0005, 5'd0);
    run("R3", 4'd1, 32'h8000_0000, 32'h0000_0001, 5'd0);
    run("R4", 4'd2, 32'h0000_0DC0, 32'h0000_3C00, 5'd0);
    run("R4", 4'd3, 32'h0000_0DC0, 32'h0000_3C00, 5'd0);
    run("R4", 4'd4, 32'hA5A5_A5A5, 32'hFFFF_0000, 5'd0);
    run("R5", 4'd5, 32'h0000_3C00, 32'h0000_0000, 5'd0);
    run("R5", 4'd5, 32'hFFFF_FFFF, 32'h0000_0000, 5'd0);
    run("R6", 4'd6, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0);
    run("R6", 4'd6, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
    run("R6", 4'd6, 32'h0000_0004, 32'h0000_0004, 5'd0);
    run("R7", 4'd7, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0);
    run("R7", 4'd7, 32'h0000_0001, 32'hFFFF_FFFF, 5'd0);
    run("R8", 4'd8, 32'h0, 32'h8000_0001, 5'd1);
    run("R8", 4'd8, 32'h0, 32'hFFFF_FFFF, 5'd31);
    run("R9", 4'd9, 32'h0, 32'h8000_0000, 5'd31);
    run("R9", 4'd9, 32'h0, 32'hF000_000F, 5'd4);
    run("R10", 4'd10, 32'h0, 32'h8000_0000, 5'd31);
    run("R10", 4'd10, 32'h0, 32'h7000_0000, 5'd4);
    run("R11", 4'd8, 32'hFFFF_FFFF, 32'h0000_0003, 5'd2);
    run("R11", 4'd0, 32'h0000_0010, 32'h0000_0001, 5'd31);
    run("R12", 4'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'd0);
    run("R12", 4'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEE, 5'd0);
    for (int c = 11; c < 16; c++)
      run("R13", 4'(c), 32'hFFFF_FFFF, 32'h1234_5678, 5'd7);

    rst = 1'b1;
    @(negedge clk);
    check("R1", '0);
    rst = 1'b0;

    for (int i = 0; i < 3000; i++) begin
      logic [3:0]    op;
      logic [W-1:0]  a, b;
      op = 4'($urandom % 16);
      a  = $urandom;
      b  = $urandom;
      case ($urandom % 8)
        0: a = b;
        1: b = 32'h8000_0000;
        2: a = 32'hFFFF_FFFF;
        default: ;
      endcase
      run("R2..R13 random", op, a, b, 5'($urandom));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule